// File: doc/BRIEF.md
# Channel Adapter Control and Interrupt Register File

This block is the register set that a processor sees in front of a disk or tape channel adapter. It sits on a 16-bit register bus with eight word locations and per-byte write enables. It holds three control/status words (called CTL, STS and AUX below), a word counter, a bus address, an address extension and a data buffer. It keeps the fields that appear in more than one register consistent, and it refuses transfer commands that arrive while the channel is busy. It forwards every accepted command write to the attached drive port as a one-cycle 6-bit strobe, and it drives one interrupt request line.

A transfer engine reports completion and errors through set-only inputs. The interrupt request combines two sources. One is an internal strobe flag, which is armed by software or loaded when the channel completes. The other is a status-change term that is true while an error condition is present and completion and interrupt enable are both set.

Reads are combinational from the addressed word. All register updates take effect at the rising clock edge that samples the write. The drive strobe is registered and is high in the cycle after the accepted write.

Top module: `chan_ctl_regs`

## Requirements
- R1: After reset, CTL (offset 0) reads 0x0080, which is the completion bit DONE at bit 7 alone. STS (offset 3) reads 0x00C0. The counter (1), address (2), buffer (4), extension (5) and AUX (6) read 0. The interrupt request is low.
- R2: `reg_be[0]` writes bits 7:0 and `reg_be[1]` writes bits 15:8. The counter, address and buffer merge the enabled bytes into their old value. Bit 0 of the address always reads 0.
- R3: STS always reads with bits 6 and 7 set. Bits 4:0 are a writable unit field.
- R4: Writing STS with `reg_be[0]` set and bit 5 set clears the adapter. CTL then reads 0x0080, every other register reads as after reset, the strobe flag is cleared and the interrupt request drops.
- R5: The interrupt-enable bit IE is CTL bit 6 and AUX bit 6. A low-byte write to either register updates both. A write to AUX or to the extension that enables only the high byte changes nothing.
- R6: CTL bits 9:8 equal bits 1:0 of the extension register. A write of the CTL high byte changes them only while DONE is set. A write to the extension shows up in CTL.
- R7: A low-byte CTL write is a transfer command when bit 0 (GO) is 1 and bits 5:1 are at least XFER_FNC_MIN (default 10, so 0x15 is a transfer). If DONE is clear, the write sets STS bit 10 (program error) and raises no drive strobe. Otherwise the write raises `drv_cmd_valid` with `drv_cmd` equal to bits 5:0 of the write.
- R8: An accepted transfer command clears DONE, TRE (CTL bit 14) and MCPE (CTL bit 13). It also clears STS bits 15:8 and AUX bits 15:10.
- R9: Any set bit in STS 15:8 makes TRE and SC (CTL bit 15) read 1. A parity report sets MCPE and TRE, and then SC reads 1 even when STS 15:8 is zero.
- R10: A CTL write with `reg_be[1]` set and bit 14 set clears TRE, STS 15:8 and AUX 15:11. MCPE and AUX bit 10 are kept.
- R11: A low-byte CTL write with bits 7 and 6 both set arms the strobe flag, which raises the interrupt request. `int_ack` clears the flag.
- R12: When `eng_done_set` takes DONE from 0 to 1, the strobe flag is loaded with the IE value held before that edge.
- R13: The interrupt request is high while the strobe flag is set, or while SC, DONE and IE are all set. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word offset for read and write |
| reg_be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed word |
| eng_done_set | input | 1 | Transfer engine sets DONE |
| eng_cs2_err | input | 8 | Error bits ORed into STS 15:8 |
| eng_cs3_err | input | 6 | Error bits ORed into AUX 15:10 |
| eng_parity_err | input | 1 | Control parity error, sets MCPE and TRE |
| int_ack | input | 1 | Interrupt acknowledge, clears the strobe flag |
| drv_cmd_valid | output | 1 | One-cycle strobe for a forwarded command |
| drv_cmd | output | 6 | Forwarded command bits |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case is a TRE without any STS error bit. Both clearing paths wipe the STS errors together with TRE, so the only way to reach it is a parity report that arrives after the errors are gone. The stimulus clears errors with an accepted transfer, injects a parity error, and checks that SC alone follows TRE. It then clears TRE and checks that MCPE survives. The load of the strobe flag on completion needs DONE clear first, so the bench reaches that case through an accepted transfer, sets IE through AUX, and only then reports completion.

// File: rtl/chan_ctl_pkg.sv
// Shared offsets, bit positions and widths for the channel control registers.
// Assumes a 16-bit register bus with eight word locations.
package chan_ctl_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;
    localparam int BAE_W  = 6;
    localparam int UAE_W  = 2;
    localparam int CMD_W  = 6;

    localparam logic [ADDR_W-1:0] OFF_CTL = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_CNT = 3'd1;
    localparam logic [ADDR_W-1:0] OFF_ADR = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_STS = 3'd3;
    localparam logic [ADDR_W-1:0] OFF_BUF = 3'd4;
    localparam logic [ADDR_W-1:0] OFF_EXT = 3'd5;
    localparam logic [ADDR_W-1:0] OFF_AUX = 3'd6;

    // CTL bit positions
    localparam int B_GO   = 0;
    localparam int B_IE   = 6;
    localparam int B_DONE = 7;
    localparam int B_TRE  = 14;
    // STS bit positions
    localparam int B_CLR  = 5;
    localparam int B_PGE  = 10;
endpackage

// File: rtl/chan_ctl_datareg.sv
// Plain byte-writable data register (counter, address, buffer).
// Bits set in MBZ always read as zero. Cleared by reset or adapter clear.
module chan_ctl_datareg
    import chan_ctl_pkg::*;
#(
    parameter logic [DATA_W-1:0] MBZ = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [1:0]        be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int LANES = DATA_W / 8;

    logic [DATA_W-1:0] merged;

    // Byte-lane merge of new data into the held value.
    always_comb begin
        merged = q;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) merged[i*8 +: 8] = wdata[i*8 +: 8];
        end
    end

    // Storage with synchronous reset and adapter clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (we)       q <= merged & ~MBZ;
    end
endmodule

// File: rtl/chan_ctl_irq.sv
// Interrupt strobe flag and request line.
// Assumes done_rise is the 0-to-1 transition of DONE in this cycle.
module chan_ctl_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic arm,
    input  logic done_rise,
    input  logic ie_q,
    input  logic int_ack,
    input  logic sc,
    input  logic done_q,
    output logic irq
);
    logic iff_q;

    // Strobe flag: software arm beats completion load beats acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  iff_q <= 1'b0;
        else if (arm)       iff_q <= 1'b1;
        else if (done_rise) iff_q <= ie_q;
        else if (int_ack)   iff_q <= 1'b0;
    end

    // Request: latched strobe or pending status change with enable.
    assign irq = iff_q | (sc & done_q & ie_q);
endmodule

// File: rtl/chan_ctl_status.sv
// Control/status words CTL, STS, AUX and the address extension.
// Applies register writes first, then ORs in engine reports. Keeps IE and
// the upper address bits stored once, so each mirror shows the same value.
module chan_ctl_status
    import chan_ctl_pkg::*;
#(
    parameter int XFER_FNC_MIN = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic              wr_sts,
    input  logic              wr_ext,
    input  logic              wr_aux,
    input  logic [1:0]        be,
    input  logic [DATA_W-1:0] wdata,
    input  logic              eng_done_set,
    input  logic [7:0]        eng_cs2_err,
    input  logic [5:0]        eng_cs3_err,
    input  logic              eng_parity_err,
    output logic [DATA_W-1:0] ctl_rd,
    output logic [DATA_W-1:0] sts_rd,
    output logic [DATA_W-1:0] aux_rd,
    output logic [DATA_W-1:0] ext_rd,
    output logic              adapter_clr,
    output logic              arm,
    output logic              done_rise,
    output logic              done_q,
    output logic              ie_q,
    output logic              sc,
    output logic              drv_cmd_valid,
    output logic [CMD_W-1:0]  drv_cmd
);
    logic             tre_q, mcpe_q, dbl_q;
    logic [7:0]       err_q;
    logic [4:0]       unit_q;
    logic [4:0]       aerr_q;
    logic [3:0]       mode_q;
    logic [BAE_W-1:0] bae_q;

    logic             n_done, n_ie, n_tre, n_mcpe, n_dbl;
    logic [7:0]       n_err;
    logic [4:0]       n_unit, n_aerr;
    logic [3:0]       n_mode;
    logic [BAE_W-1:0] n_bae;
    logic             is_xfer, fire;
    logic             tre_rd;

    // Transfer-class decode of a command write.
    assign is_xfer = wdata[B_GO] && (wdata[5:1] >= 5'(XFER_FNC_MIN));
    assign adapter_clr = wr_sts && be[0] && wdata[B_CLR];

    // Next-state of every status field.
    always_comb begin
        n_done = done_q; n_ie = ie_q; n_tre = tre_q; n_mcpe = mcpe_q;
        n_dbl = dbl_q; n_err = err_q; n_unit = unit_q; n_aerr = aerr_q;
        n_mode = mode_q; n_bae = bae_q;
        arm = 1'b0; fire = 1'b0;
        if (wr_ctl) begin
            if (be[1] && wdata[B_TRE]) begin
                n_tre = 1'b0; n_err = '0; n_aerr = '0;
            end
            if (be[1] && done_q) n_bae[UAE_W-1:0] = wdata[8 +: UAE_W];
            if (be[0]) begin
                arm  = wdata[B_DONE] && wdata[B_IE];
                n_ie = wdata[B_IE];
                if (is_xfer && !done_q) begin
                    n_err[B_PGE-8] = 1'b1;
                end else begin
                    fire = 1'b1;
                    if (is_xfer) begin
                        n_tre = 1'b0; n_mcpe = 1'b0; n_done = 1'b0;
                        n_err = '0; n_aerr = '0; n_dbl = 1'b0;
                    end
                end
            end
        end
        if (wr_sts && be[0]) n_unit = wdata[4:0];
        if (wr_ext && be[0]) n_bae = wdata[BAE_W-1:0];
        if (wr_aux && be[0]) begin
            n_mode = wdata[3:0];
            n_ie   = wdata[B_IE];
        end
        n_err  = n_err | eng_cs2_err;
        n_aerr = n_aerr | eng_cs3_err[5:1];
        n_dbl  = n_dbl | eng_cs3_err[0];
        if (eng_parity_err) begin
            n_mcpe = 1'b1; n_tre = 1'b1;
        end
        if (eng_done_set) n_done = 1'b1;
    end

    assign done_rise = n_done && !done_q && !adapter_clr;

    // Status storage; adapter clear restores the reset image.
    always_ff @(posedge clk) begin
        if (!rst_n || adapter_clr) begin
            done_q <= 1'b1; ie_q <= 1'b0; tre_q <= 1'b0; mcpe_q <= 1'b0;
            dbl_q <= 1'b0; err_q <= '0; unit_q <= '0; aerr_q <= '0;
            mode_q <= '0; bae_q <= '0;
        end else begin
            done_q <= n_done; ie_q <= n_ie; tre_q <= n_tre; mcpe_q <= n_mcpe;
            dbl_q <= n_dbl; err_q <= n_err; unit_q <= n_unit; aerr_q <= n_aerr;
            mode_q <= n_mode; bae_q <= n_bae;
        end
    end

    // Registered command strobe toward the drive port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_cmd_valid <= 1'b0;
            drv_cmd       <= '0;
        end else begin
            drv_cmd_valid <= fire;
            if (fire) drv_cmd <= wdata[CMD_W-1:0];
        end
    end

    assign tre_rd = tre_q | (|err_q);
    assign sc     = tre_rd;

    // Read images of the four words.
    assign ctl_rd = {sc, tre_rd, mcpe_q, 3'b000, bae_q[UAE_W-1:0],
                     done_q, ie_q, 6'b000000};
    assign sts_rd = {err_q, 2'b11, 1'b0, unit_q};
    assign aux_rd = {aerr_q, dbl_q, 3'b000, ie_q, 2'b00, mode_q};
    assign ext_rd = {{(DATA_W-BAE_W){1'b0}}, bae_q};
endmodule

// File: rtl/chan_ctl_regs.sv
// Top of the channel control register file: address decode, data registers,
// status words, interrupt logic and read multiplexer.
module chan_ctl_regs
    import chan_ctl_pkg::*;
#(
    parameter int XFER_FNC_MIN = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_be,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_done_set,
    input  logic [7:0]        eng_cs2_err,
    input  logic [5:0]        eng_cs3_err,
    input  logic              eng_parity_err,
    input  logic              int_ack,
    output logic              drv_cmd_valid,
    output logic [CMD_W-1:0]  drv_cmd,
    output logic              irq
);
    localparam int NLOC  = 1 << ADDR_W;
    localparam int NDATA = 3;
    localparam logic [ADDR_W-1:0] DOFF [NDATA] = '{OFF_CNT, OFF_ADR, OFF_BUF};
    localparam logic [DATA_W-1:0] DMBZ [NDATA] = '{16'h0000, 16'h0001, 16'h0000};

    logic [NLOC-1:0]   wsel;
    logic [DATA_W-1:0] dq [NDATA];
    logic [DATA_W-1:0] ctl_rd, sts_rd, aux_rd, ext_rd;
    logic              adapter_clr, arm, done_rise, st_done, st_ie, st_sc;

    // One-hot write select per word location.
    always_comb begin
        wsel = '0;
        wsel[reg_addr] = reg_wr;
    end

    for (genvar g = 0; g < NDATA; g++) begin : g_data
        chan_ctl_datareg #(.MBZ(DMBZ[g])) reg_i (
            .clk(clk), .rst_n(rst_n), .clr(adapter_clr),
            .we(wsel[DOFF[g]]), .be(reg_be), .wdata(reg_wdata), .q(dq[g])
        );
    end

    chan_ctl_status #(.XFER_FNC_MIN(XFER_FNC_MIN)) status_i (
        .clk(clk), .rst_n(rst_n),
        .wr_ctl(wsel[OFF_CTL]), .wr_sts(wsel[OFF_STS]),
        .wr_ext(wsel[OFF_EXT]), .wr_aux(wsel[OFF_AUX]),
        .be(reg_be), .wdata(reg_wdata),
        .eng_done_set(eng_done_set), .eng_cs2_err(eng_cs2_err),
        .eng_cs3_err(eng_cs3_err), .eng_parity_err(eng_parity_err),
        .ctl_rd(ctl_rd), .sts_rd(sts_rd), .aux_rd(aux_rd), .ext_rd(ext_rd),
        .adapter_clr(adapter_clr), .arm(arm), .done_rise(done_rise),
        .done_q(st_done), .ie_q(st_ie), .sc(st_sc),
        .drv_cmd_valid(drv_cmd_valid), .drv_cmd(drv_cmd)
    );

    chan_ctl_irq irq_i (
        .clk(clk), .rst_n(rst_n), .clr(adapter_clr), .arm(arm),
        .done_rise(done_rise), .ie_q(st_ie), .int_ack(int_ack),
        .sc(st_sc), .done_q(st_done), .irq(irq)
    );

    // Read multiplexer by word offset.
    always_comb begin
        case (reg_addr)
            OFF_CTL: reg_rdata = ctl_rd;
            OFF_CNT: reg_rdata = dq[0];
            OFF_ADR: reg_rdata = dq[1];
            OFF_STS: reg_rdata = sts_rd;
            OFF_BUF: reg_rdata = dq[2];
            OFF_EXT: reg_rdata = ext_rd;
            OFF_AUX: reg_rdata = aux_rd;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/chan_ctl_regs_chk.sv
// Temporal checks for chan_ctl_regs, attached through bind.
module chan_ctl_regs_chk
    import chan_ctl_pkg::*;
#(
    parameter int XFER_FNC_MIN = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [1:0]        reg_be,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              eng_done_set,
    input logic [7:0]        eng_cs2_err,
    input logic              drv_cmd_valid,
    input logic              irq,
    input logic              st_done,
    input logic              st_sc
);
    logic ctl_lo, xfer;
    assign ctl_lo = reg_wr && reg_addr == OFF_CTL && reg_be[0];
    assign xfer   = reg_wdata[B_GO] && (reg_wdata[5:1] >= 5'(XFER_FNC_MIN));

    a_r3_sts_ready: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == OFF_STS |-> reg_rdata[7:6] == 2'b11);

    a_r4_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_STS && reg_be[0] && reg_wdata[B_CLR])
        |=> (!irq && st_done));

    a_r7_busy_xfer_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_lo && xfer && !st_done) |=> !drv_cmd_valid);

    a_r8_xfer_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_lo && xfer && st_done && !eng_done_set) |=> (!st_done && drv_cmd_valid));

    a_r9_err_forces_sc: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_cs2_err != 8'h00 && !reg_wr) |=> st_sc);

    a_r11_arm_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_lo && reg_wdata[B_DONE] && reg_wdata[B_IE]) |=> irq);
endmodule

bind chan_ctl_regs chan_ctl_regs_chk #(.XFER_FNC_MIN(XFER_FNC_MIN)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_done_set(eng_done_set), .eng_cs2_err(eng_cs2_err),
    .drv_cmd_valid(drv_cmd_valid), .irq(irq),
    .st_done(st_done), .st_sc(st_sc)
);

// File: tb/chan_ctl_regs_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module chan_ctl_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [1:0]  reg_be = 2'b00;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        eng_done_set = 1'b0;
    logic [7:0]  eng_cs2_err = 8'h0;
    logic [5:0]  eng_cs3_err = 6'h0;
    logic        eng_parity_err = 1'b0;
    logic        int_ack = 1'b0;
    logic        drv_cmd_valid;
    logic [5:0]  drv_cmd;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    chan_ctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_done_set(eng_done_set), .eng_cs2_err(eng_cs2_err),
        .eng_cs3_err(eng_cs3_err), .eng_parity_err(eng_parity_err),
        .int_ack(int_ack), .drv_cmd_valid(drv_cmd_valid), .drv_cmd(drv_cmd),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 2'b00;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
        reg_addr = a;
        #0.5;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic eng(input logic done, input logic [7:0] e2, input logic [5:0] e3,
                       input logic par, input logic ack);
        @(negedge clk);
        eng_done_set = done; eng_cs2_err = e2; eng_cs3_err = e3;
        eng_parity_err = par; int_ack = ack;
        @(negedge clk);
        eng_done_set = 1'b0; eng_cs2_err = 8'h0; eng_cs3_err = 6'h0;
        eng_parity_err = 1'b0; int_ack = 1'b0;
    endtask

    task automatic t_reset();
        rd_chk("R1 ctl", 3'd0, 16'h0080);
        rd_chk("R3 sts", 3'd3, 16'h00C0);
        rd_chk("R1 cnt", 3'd1, 16'h0000);
        rd_chk("R1 ext", 3'd5, 16'h0000);
        rd_chk("R1 aux", 3'd6, 16'h0000);
        chk("R1 irq", {15'h0, irq}, 16'h0000);
    endtask

    task automatic t_bytes();
        wr(3'd1, 2'b11, 16'h1234);
        wr(3'd1, 2'b10, 16'hABFF);
        rd_chk("R2 high lane", 3'd1, 16'hAB34);
        wr(3'd1, 2'b01, 16'hFFCD);
        rd_chk("R2 low lane", 3'd1, 16'hABCD);
        wr(3'd2, 2'b11, 16'h5679);
        rd_chk("R2 adr bit0", 3'd2, 16'h5678);
        wr(3'd4, 2'b10, 16'h9911);
        rd_chk("R2 buf", 3'd4, 16'h9900);
    endtask

    task automatic t_ie_mirror();
        wr(3'd0, 2'b01, 16'h0040);
        rd_chk("R5 aux ie", 3'd6, 16'h0040);
        chk("R13 no sc no irq", {15'h0, irq}, 16'h0000);
        wr(3'd6, 2'b10, 16'hFFFF);
        rd_chk("R5 aux hi ignored", 3'd6, 16'h0040);
        wr(3'd6, 2'b11, 16'h0000);
        rd_chk("R5 ctl ie off", 3'd0, 16'h0080);
    endtask

    task automatic t_uae();
        wr(3'd0, 2'b10, 16'h0300);
        rd_chk("R6 ctl uae", 3'd0, 16'h0380);
        rd_chk("R6 ext mirror", 3'd5, 16'h0003);
        wr(3'd5, 2'b11, 16'h002D);
        rd_chk("R6 ctl from ext", 3'd0, 16'h0180);
        wr(3'd5, 2'b10, 16'hFF00);
        rd_chk("R5 ext hi ignored", 3'd5, 16'h002D);
    endtask

    task automatic t_xfer();
        eng(1'b0, 8'h01, 6'h3F, 1'b1, 1'b0);
        rd_chk("R9 ctl errs", 3'd0, 16'hE180);
        rd_chk("R9 sts errs", 3'd3, 16'h01C0);
        rd_chk("R9 aux errs", 3'd6, 16'hFC00);
        wr(3'd0, 2'b01, 16'h0015);
        chk("R7 accepted strobe", {15'h0, drv_cmd_valid}, 16'h0001);
        chk("R7 cmd bits", {10'h0, drv_cmd}, 16'h0015);
        rd_chk("R8 ctl cleared", 3'd0, 16'h0100);
        rd_chk("R8 sts cleared", 3'd3, 16'h00C0);
        rd_chk("R8 aux cleared", 3'd6, 16'h0000);
        wr(3'd0, 2'b01, 16'h0013);
        chk("R7 non-xfer busy ok", {15'h0, drv_cmd_valid}, 16'h0001);
        rd_chk("R7 no pge", 3'd3, 16'h00C0);
        wr(3'd0, 2'b01, 16'h0015);
        chk("R7 blocked", {15'h0, drv_cmd_valid}, 16'h0000);
        rd_chk("R7 pge", 3'd3, 16'h04C0);
        rd_chk("R9 ctl sc tre", 3'd0, 16'hC100);
        wr(3'd0, 2'b10, 16'h0200);
        rd_chk("R6 uae locked", 3'd0, 16'hC100);
        wr(3'd0, 2'b10, 16'h4000);
        rd_chk("R10 ctl", 3'd0, 16'h0100);
        rd_chk("R10 sts", 3'd3, 16'h00C0);
        eng(1'b0, 8'h00, 6'h3F, 1'b0, 1'b0);
        wr(3'd0, 2'b10, 16'h4000);
        rd_chk("R10 aux keeps dbl", 3'd6, 16'h0400);
        eng(1'b0, 8'h00, 6'h00, 1'b1, 1'b0);
        rd_chk("R9 tre only sc", 3'd0, 16'hE100);
        wr(3'd0, 2'b10, 16'h4000);
        rd_chk("R10 mcpe kept", 3'd0, 16'h2100);
    endtask

    task automatic t_done_irq();
        wr(3'd6, 2'b01, 16'h0040);
        chk("R13 idle irq", {15'h0, irq}, 16'h0000);
        eng(1'b1, 8'h00, 6'h00, 1'b0, 1'b0);
        chk("R12 done loads ie", {15'h0, irq}, 16'h0001);
        rd_chk("R12 ctl", 3'd0, 16'h21C0);
        eng(1'b0, 8'h00, 6'h00, 1'b0, 1'b1);
        chk("R11 ack clears", {15'h0, irq}, 16'h0000);
        wr(3'd0, 2'b01, 16'h00C0);
        chk("R11 arm", {15'h0, irq}, 16'h0001);
        eng(1'b0, 8'h00, 6'h00, 1'b0, 1'b1);
        chk("R11 ack again", {15'h0, irq}, 16'h0000);
        eng(1'b0, 8'h80, 6'h00, 1'b0, 1'b0);
        chk("R13 status term", {15'h0, irq}, 16'h0001);
        wr(3'd0, 2'b01, 16'h0015);
        chk("R13 after accept", {15'h0, irq}, 16'h0000);
        eng(1'b1, 8'h00, 6'h00, 1'b0, 1'b0);
        wr(3'd6, 2'b01, 16'h0040);
        chk("R12 loaded zero", {15'h0, irq}, 16'h0000);
    endtask

    task automatic t_clear();
        wr(3'd3, 2'b01, 16'h0007);
        rd_chk("R3 unit", 3'd3, 16'h00C7);
        wr(3'd1, 2'b11, 16'hFFFF);
        wr(3'd0, 2'b01, 16'h00C0);
        chk("R11 armed pre clear", {15'h0, irq}, 16'h0001);
        wr(3'd3, 2'b01, 16'h0020);
        chk("R4 irq", {15'h0, irq}, 16'h0000);
        rd_chk("R4 ctl", 3'd0, 16'h0080);
        rd_chk("R4 sts", 3'd3, 16'h00C0);
        rd_chk("R4 cnt", 3'd1, 16'h0000);
        rd_chk("R4 ext", 3'd5, 16'h0000);
        rd_chk("R4 aux", 3'd6, 16'h0000);
        wr(3'd6, 2'b01, 16'h0040);
        chk("R4 flag gone", {15'h0, irq}, 16'h0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bytes();
        t_ie_mirror();
        t_uae();
        t_xfer();
        t_done_irq();
        t_clear();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule